// File: doc/BRIEF.md
# DMA Channel Transfer Count and Status Unit

This block keeps the transfer bookkeeping of one DMA channel. It holds a 24-bit count of the bytes that remain to be moved and an 8-bit status byte. Both sit in a single 32-bit register that a register bus reads and writes at one address. Software loads the count. A transfer sequencer then signals the start of a sequence, the access size and, for each write, the moment its address phase completes. On each of those completions the unit subtracts the access size from the count.

At start the unit checks that the count suits the chosen access size. A count that is not a multiple of the size sets a configuration error, and no transfer begins. A count of zero completes at once. Any other count makes the channel busy and raises a permit output that tells the sequencer it may move data. When the last write completes, busy drops and DONE is set. The only status bit software can act on is DONE: writing a one to it clears the whole status byte and re-arms the channel.

Top module: `xfer_count_status`

## Requirements
- R1: After synchronous active-low reset the register reads 0 and `xfer_permit` is low.
- R2: Read data is the status byte in bits 31:24 above the count in bits 23:0. Write strobe bits 0, 1 and 2 each load one byte of the count (bits 7:0, 15:8 and 23:16). Strobe bit 3 selects the status byte. Status bits are DONE = bit 24, BSY = bit 25 and CFG_ERR = bit 30. Every other status bit reads 0.
- R3: A start with a nonzero count that is a multiple of the access size sets BSY, and `xfer_permit` goes high in the next cycle.
- R4: While BSY is set, each write-completion pulse lowers the count by the latched access size: 1, 2, 4 or 16 for size codes 0, 1, 2 and 3. A size change during the transfer has no effect.
- R5: The completion that brings the count to zero clears BSY, sets DONE and drops `xfer_permit`.
- R6: A start with size code 1, 2 or 3 and a count that is not a multiple of 2, 4 or 16 sets CFG_ERR. BSY stays clear, the count is unchanged and `xfer_permit` stays low.
- R7: A start with size code 0 never sets CFG_ERR.
- R8: A start with a count of zero sets DONE in the next cycle and never sets BSY.
- R9: A status-byte write with bit 24 = 1 clears every status bit, BSY included. A status-byte write with bit 24 = 0 changes nothing, whatever its other bits hold.
- R10: Count writes are ignored while BSY is set.
- R11: A start is ignored unless the status byte is all zero.
- R12: Write-completion pulses are ignored while BSY is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write request |
| reg_wr_strb | input | 4 | Byte strobes for the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Register contents: status byte and count |
| seq_start | input | 1 | One-cycle pulse that starts a sequence |
| seq_size | input | 2 | Access size code: 0 byte, 1 word, 2 longword, 3 line |
| seq_wr_done | input | 1 | Pulse when a write's address phase completes |
| xfer_permit | output | 1 | High while the channel may transfer |

## Verification
Some properties are checked on every cycle. CFG_ERR and BSY are never set together, and the permit output is low whenever CFG_ERR is set. DONE rises only with a zero count. A busy channel's count either holds or drops by exactly the latched step. An idle count moves only on a write. A DONE write empties the status byte, and a start that is not armed changes nothing. Other behaviour needs whole scenarios in the bench to show it: the full countdown for each size, the alignment verdict for each size against one odd count, completion on zero, the byte-lane effect of partial strobes, and re-arming after DONE or an error.

// File: rtl/xcs_pkg.sv
// Package: shared types and field positions for the transfer count/status unit.
// Assumes a 24-bit count field and an 8-bit status byte in one register.
package xcs_pkg;

    // Access size code supplied by the transfer sequencer.
    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_WORD = 2'd1,
        ACC_LONG = 2'd2,
        ACC_LINE = 2'd3
    } acc_size_e;

    localparam int STAT_W      = 8;
    localparam int STEP_W      = 5;   // wide enough for a 16-byte step
    localparam int ST_DONE_BIT = 0;   // register bit 24
    localparam int ST_BSY_BIT  = 1;   // register bit 25
    localparam int ST_CE_BIT   = 6;   // register bit 30

endpackage

// File: rtl/xcs_step_dec.sv
// Module: turns an access size into the byte step and judges whether the
// low bits of a count fit that size. Purely combinational.
// Assumes the count's low four bits are enough to test alignment up to 16.
module xcs_step_dec
    import xcs_pkg::*;
(
    input  acc_size_e          size_i,
    input  logic [3:0]         cnt_low_i,
    output logic [STEP_W-1:0]  step_o,
    output logic               misaligned_o
);

    logic [3:0] low_mask;

    // Map size code to step and the mask of count bits that must be zero.
    always_comb begin
        unique case (size_i)
            ACC_BYTE: begin step_o = STEP_W'(1);  low_mask = 4'b0000; end
            ACC_WORD: begin step_o = STEP_W'(2);  low_mask = 4'b0001; end
            ACC_LONG: begin step_o = STEP_W'(4);  low_mask = 4'b0011; end
            default:  begin step_o = STEP_W'(16); low_mask = 4'b1111; end
        endcase
    end

    // Any set bit under the mask means the count is not a size multiple.
    always_comb misaligned_o = |(cnt_low_i & low_mask);

endmodule

// File: rtl/xcs_count_reg.sv
// Module: remaining-byte counter. Software loads it bytewise while the
// channel is idle; while locked (busy) it only steps down on completions.
// Assumes CNT_W is a multiple of 8 and the sequencer stops at zero
// (an oversized step saturates at zero rather than wrapping).
module xcs_count_reg
    import xcs_pkg::*;
#(
    parameter int CNT_W = 24,
    localparam int NB   = CNT_W / 8
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [NB-1:0]      wr_strb_i,
    input  logic [CNT_W-1:0]   wr_data_i,
    input  logic               lock_i,
    input  logic               dec_i,
    input  logic [STEP_W-1:0]  step_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               zero_o,
    output logic               last_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] step_ext;

    // Widen the step to count width.
    always_comb step_ext = CNT_W'(step_i);

    // Count update: decrement while locked, byte-lane load while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (lock_i) begin
            if (dec_i) begin
                cnt_q <= (cnt_q <= step_ext) ? '0 : cnt_q - step_ext;
            end
        end else if (wr_en_i) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_strb_i[b]) cnt_q[8*b +: 8] <= wr_data_i[8*b +: 8];
            end
        end
    end

    // Flags consumed by the status logic.
    always_comb begin
        cnt_o  = cnt_q;
        zero_o = (cnt_q == '0);
        last_o = (cnt_q <= step_ext);
    end

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && !dec_i) |=> $stable(cnt_q)); // R10
    AST_DEC_BY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && dec_i && cnt_q > step_ext) |=> (cnt_q == $past(cnt_q) - $past(step_ext))); // R4
    AST_IDLE_NO_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_i && !wr_en_i) |=> $stable(cnt_q)); // R12

endmodule

// File: rtl/xcs_status_reg.sv
// Module: status byte and latched access size. Hardware sets BSY, DONE or
// CFG_ERR in response to start and completion events; software may only
// act through DONE, where a one clears the whole byte.
// Assumes start is honoured only when the byte is all zero (armed).
module xcs_status_reg
    import xcs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_wr_i,
    input  logic [STAT_W-1:0]  sw_data_i,
    input  logic               start_i,
    input  acc_size_e          size_i,
    input  logic               misaligned_i,
    input  logic               cnt_zero_i,
    input  logic               dec_i,
    input  logic               last_i,
    output logic [STAT_W-1:0]  stat_o,
    output logic               busy_o,
    output acc_size_e          size_o
);

    logic [STAT_W-1:0] stat_q, stat_d;
    acc_size_e         size_q;
    logic              armed, sw_clear, start_ok;

    // Decode the software clear and whether a start is accepted.
    always_comb begin
        armed    = (stat_q == '0);
        sw_clear = sw_wr_i && sw_data_i[ST_DONE_BIT];
        start_ok = start_i && armed && !sw_clear;
    end

    // Next-state of the status byte; a software clear wins over events.
    always_comb begin
        stat_d = stat_q;
        if (sw_clear) begin
            stat_d = '0;
        end else if (start_ok) begin
            if (misaligned_i)    stat_d[ST_CE_BIT]   = 1'b1;
            else if (cnt_zero_i) stat_d[ST_DONE_BIT] = 1'b1;
            else                 stat_d[ST_BSY_BIT]  = 1'b1;
        end else if (stat_q[ST_BSY_BIT] && dec_i && last_i) begin
            stat_d[ST_BSY_BIT]  = 1'b0;
            stat_d[ST_DONE_BIT] = 1'b1;
        end
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // Access size latched on an accepted start for use during the transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)        size_q <= ACC_BYTE;
        else if (start_ok) size_q <= size_i;
    end

    // Outputs.
    always_comb begin
        stat_o = stat_q;
        busy_o = stat_q[ST_BSY_BIT];
        size_o = size_q;
    end

    AST_CE_EXCL_BSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_q[ST_CE_BIT] && stat_q[ST_BSY_BIT])); // R6
    AST_DONE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[ST_DONE_BIT]) |-> cnt_zero_i); // R5
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clear |=> (stat_q == '0)); // R9
    AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && sw_data_i != '0 && !sw_data_i[ST_DONE_BIT] && !start_i && !dec_i)
        |=> $stable(stat_q)); // R9
    AST_START_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !armed && !sw_clear && !stat_q[ST_BSY_BIT]) |=> $stable(stat_q)); // R11

endmodule

// File: rtl/xfer_count_status.sv
// Module (top): one DMA channel's byte count and status in one 32-bit
// register. Wires the count register, status register and size decoder,
// forms the register read view and the transfer permit.
// Assumes the sequencer stops issuing completions when permit drops.
module xfer_count_status
    import xcs_pkg::*;
#(
    parameter int CNT_W  = 24,
    localparam int REG_W = CNT_W + STAT_W,
    localparam int NBC   = CNT_W / 8,
    localparam int NBR   = REG_W / 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [NBR-1:0]    reg_wr_strb,
    input  logic [REG_W-1:0]  reg_wr_data,
    output logic [REG_W-1:0]  reg_rd_data,
    input  logic              seq_start,
    input  logic [1:0]        seq_size,
    input  logic              seq_wr_done,
    output logic              xfer_permit
);

    logic [CNT_W-1:0]  cnt;
    logic              cnt_zero, cnt_last;
    logic [STAT_W-1:0] stat;
    logic              busy;
    acc_size_e         size_lat, size_in, size_sel;
    logic [STEP_W-1:0] step;
    logic              misaligned;
    logic              stat_wr;

    // Input size as enum; the decoder sees the latched size while busy.
    always_comb begin
        size_in  = acc_size_e'(seq_size);
        size_sel = busy ? size_lat : size_in;
        stat_wr  = reg_wr_en && reg_wr_strb[NBC];
    end

    xcs_step_dec i_step_dec (
        .size_i       (size_sel),
        .cnt_low_i    (cnt[3:0]),
        .step_o       (step),
        .misaligned_o (misaligned)
    );

    xcs_count_reg #(.CNT_W(CNT_W)) i_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (reg_wr_en),
        .wr_strb_i (reg_wr_strb[NBC-1:0]),
        .wr_data_i (reg_wr_data[CNT_W-1:0]),
        .lock_i    (busy),
        .dec_i     (seq_wr_done),
        .step_i    (step),
        .cnt_o     (cnt),
        .zero_o    (cnt_zero),
        .last_o    (cnt_last)
    );

    xcs_status_reg i_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_wr_i      (stat_wr),
        .sw_data_i    (reg_wr_data[REG_W-1:CNT_W]),
        .start_i      (seq_start),
        .size_i       (size_in),
        .misaligned_i (misaligned),
        .cnt_zero_i   (cnt_zero),
        .dec_i        (seq_wr_done),
        .last_i       (cnt_last),
        .stat_o       (stat),
        .busy_o       (busy),
        .size_o       (size_lat)
    );

    // Register read view and permit toward the sequencer.
    always_comb begin
        reg_rd_data = {stat, cnt};
        xfer_permit = busy && !stat[ST_CE_BIT];
    end

    AST_PERMIT_NOT_CE: assert property (@(posedge clk) disable iff (!rst_n)
        stat[ST_CE_BIT] |-> !xfer_permit); // R6
    AST_BYTE_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start && size_in == ACC_BYTE && stat == '0 && !stat_wr) |=> !stat[ST_CE_BIT]); // R7
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> xfer_permit); // R3

endmodule

// File: tb/test_xfer_count_status.sv
module test_xfer_count_status;

    localparam logic [31:0] DONE = 32'h0100_0000;
    localparam logic [31:0] BSY  = 32'h0200_0000;
    localparam logic [31:0] CE   = 32'h4000_0000;

    typedef struct {
        logic [31:0] data;
        logic        permit;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_wr_strb = '0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        seq_start = 1'b0;
    logic [1:0]  seq_size = '0;
    logic        seq_wr_done = 1'b0;
    logic        xfer_permit;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    always #2 clk = ~clk;

    xfer_count_status i_xfer_count_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_strb (reg_wr_strb),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .seq_start   (seq_start),
        .seq_size    (seq_size),
        .seq_wr_done (seq_wr_done),
        .xfer_permit (xfer_permit)
    );

    // Driver: apply one cycle of stimulus and queue the result expected after it.
    task automatic step(input logic wr, input logic [3:0] strb, input logic [31:0] d,
                        input logic st, input logic [1:0] sz, input logic dn,
                        input logic [31:0] exp_d, input logic exp_p, input string tag);
        @(negedge clk);
        reg_wr_en   = wr;
        reg_wr_strb = strb;
        reg_wr_data = d;
        seq_start   = st;
        seq_size    = sz;
        seq_wr_done = dn;
        q.push_back('{exp_d, exp_p, tag});
    endtask

    task automatic idle(input logic [31:0] exp_d, input logic exp_p, input string tag);
        step(0, 4'b0000, 32'h0, 0, 2'd0, 0, exp_d, exp_p, tag);
    endtask

    // Monitor: compare each queued expectation just after the clock edge.
    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (reg_rd_data !== e.data || xfer_permit !== e.permit) begin
                n_bad++;
                $display("FAIL %s: got data=%h permit=%b, expected data=%h permit=%b",
                         e.tag, reg_rd_data, xfer_permit, e.data, e.permit);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(32'h0, 0, "R1 reset state");

        // Word transfer of 6 bytes
        step(1, 4'b0111, 32'h6, 0, 2'd0, 0, 32'h6, 0, "R2 count load");
        step(0, 4'b0000, 32'h0, 1, 2'd1, 0, BSY | 32'h6, 1, "R3 word start");
        step(0, 4'b0000, 32'h0, 0, 2'd1, 1, BSY | 32'h4, 1, "R4 word step");
        step(0, 4'b0000, 32'h0, 0, 2'd1, 1, BSY | 32'h2, 1, "R4 word step");
        step(0, 4'b0000, 32'h0, 0, 2'd1, 1, DONE, 0, "R5 done at zero");
        step(1, 4'b1000, 32'h0, 0, 2'd0, 0, DONE, 0, "R9 zero write no effect");
        step(1, 4'b1000, 32'hFE00_0000, 0, 2'd0, 0, DONE, 0, "R9 other bits no effect");
        step(0, 4'b0000, 32'h0, 1, 2'd0, 0, DONE, 0, "R11 start while DONE");
        step(1, 4'b0111, 32'h20, 0, 2'd0, 0, DONE | 32'h20, 0, "R2 load while not busy");
        step(1, 4'b1000, 32'h0100_0000, 0, 2'd0, 0, 32'h20, 0, "R9 DONE clear");

        // Line transfer of 32 bytes, size input changed mid-transfer
        step(0, 4'b0000, 32'h0, 1, 2'd3, 0, BSY | 32'h20, 1, "R3 line start");
        step(0, 4'b0000, 32'h0, 0, 2'd0, 1, BSY | 32'h10, 1, "R4 line step latched");
        step(1, 4'b0111, 32'h55, 0, 2'd0, 0, BSY | 32'h10, 1, "R10 write ignored busy");
        step(0, 4'b0000, 32'h0, 0, 2'd0, 1, DONE, 0, "R5 line done");
        step(1, 4'b1000, 32'h0100_0000, 0, 2'd0, 0, 32'h0, 0, "R9 clear");

        // Odd count 11 against each size
        step(1, 4'b0111, 32'hB, 0, 2'd0, 0, 32'hB, 0, "R2 load 11");
        step(0, 4'b0000, 32'h0, 1, 2'd2, 0, CE | 32'hB, 0, "R6 long misaligned");
        step(0, 4'b0000, 32'h0, 0, 2'd0, 1, CE | 32'hB, 0, "R12 pulse ignored on error");
        step(0, 4'b0000, 32'h0, 1, 2'd3, 0, CE | 32'hB, 0, "R11 start while CFG_ERR");
        step(1, 4'b1000, 32'h0100_0000, 0, 2'd0, 0, 32'hB, 0, "R9 clear error");
        step(0, 4'b0000, 32'h0, 1, 2'd3, 0, CE | 32'hB, 0, "R6 line misaligned");
        step(1, 4'b1000, 32'h0100_0000, 0, 2'd0, 0, 32'hB, 0, "R9 clear error");
        step(0, 4'b0000, 32'h0, 1, 2'd1, 0, CE | 32'hB, 0, "R6 word misaligned");
        step(1, 4'b1000, 32'h0100_0000, 0, 2'd0, 0, 32'hB, 0, "R9 clear error");
        step(0, 4'b0000, 32'h0, 1, 2'd0, 0, BSY | 32'hB, 1, "R7 byte start no error");
        for (int i = 1; i <= 11; i++) begin
            if (i == 11) step(0, 4'b0000, 32'h0, 0, 2'd0, 1, DONE, 0, "R5 byte done");
            else step(0, 4'b0000, 32'h0, 0, 2'd0, 1, BSY | (32'd11 - 32'(i)), 1, "R4 byte step");
        end
        step(1, 4'b1000, 32'h0100_0000, 0, 2'd0, 0, 32'h0, 0, "R9 clear");

        // Zero-count start
        step(0, 4'b0000, 32'h0, 1, 2'd2, 0, DONE, 0, "R8 zero count start");
        idle(DONE, 0, "R8 no busy after zero start");

        // Partial strobes, clear while busy
        step(1, 4'b0101, 32'h1234_5678, 0, 2'd0, 0, DONE | 32'h0034_0078, 0, "R2 byte lanes");
        step(1, 4'b1000, 32'h0100_0000, 0, 2'd0, 0, 32'h0034_0078, 0, "R9 clear");
        step(0, 4'b0000, 32'h0, 1, 2'd0, 0, BSY | 32'h0034_0078, 1, "R3 byte start");
        step(1, 4'b1000, 32'h0100_0000, 0, 2'd0, 0, 32'h0034_0078, 0, "R9 clear while busy");
        step(0, 4'b0000, 32'h0, 0, 2'd0, 1, 32'h0034_0078, 0, "R12 pulse ignored idle");
        idle(32'h0034_0078, 0, "R12 idle hold");

        while (q.size() > 0) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #800000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got no completion, expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule